// File: doc/BRIEF.md
# Mains-Synchronized Clock Calendar

This block keeps wall-clock time and a calendar. Its one-second beat comes from counting rising edges of a digitized mains pulse. A configuration input chooses whether 50 or 60 edges make one second. When mains edges stop arriving, the block switches to a crystal-rate enable and counts those ticks instead. Once mains edges arrive steadily again, it switches back to mains.

All time and date fields are held in BCD: seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year. The calendar applies month lengths and leap years. It can also apply a daylight-saving step at 02:00 on a configured start date and on a configured end date. A simple write port loads any field. Every field is presented on output ports for neighbouring logic.

The mains input passes through a small synchronizer before edge detection. The crystal input is assumed to be a one-cycle enable that is already in the system clock domain.

Top module: `mains_rtc`

## Requirements
- R1: After synchronous active-low reset the time is 00:00:00, day of week 0, date 01, month 01, year 00, `src_xtal_o` is 0, and the block counts mains edges.
- R2: On mains, the seconds field advances once per 50 synchronized rising edges of `mains_in` when `sel_60` is 0, and once per 60 edges when `sel_60` is 1.
- R3: A write with `wr_addr` 0..6 loads seconds, minutes, hours, day of week (`wr_data[2:0]`), date, month or year respectively. Any write clears the sub-second count, so the next second arrives only after a full count. Fields change only on a second advance or a write.
- R4: Seconds and minutes wrap 59 to 00 with a carry. Hours wrap 23 to 00 with a day carry. All three stay valid BCD.
- R5: A day carry advances the day of week 0..6, wrapping 6 to 0. The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other long months, and the month wraps from 12 to 01.
- R6: A BCD year divisible by 4 (00 included) gives February 29 days; any other year gives 28. On the rollover after December 31, year 99 becomes 00.
- R7: After ceil(3*XTAL_HZ/50) `xtal_tick` pulses with no mains edge, `src_xtal_o` goes to 1. From then on, one second is XTAL_HZ crystal ticks.
- R8: While on crystal, LOCK_EDGES mains edges with no intervening timeout return `src_xtal_o` to 0. Fewer edges do not. Counting then resumes on mains from a cleared sub-second count.
- R9: With `dst_en` at 1, on the date given by `dst_on_month`/`dst_on_date`, the step after 01:59:59 goes to 03:00:00.
- R10: With `dst_en` at 1, on the date given by `dst_off_month`/`dst_off_date`, the step after 01:59:59 goes to 01:00:00 once. The next time 01:59:59 occurs that day, it steps to 02:00:00.
- R11: With `dst_en` at 0, 01:59:59 always steps to 02:00:00.
- R12: `sec_pulse_o` is a single-cycle pulse, issued once per second advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mains_in | input | 1 | Digitized mains pulse (asynchronous) |
| xtal_tick | input | 1 | One-cycle enable at crystal rate |
| sel_60 | input | 1 | 1 selects 60 edges per second, 0 selects 50 |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year |
| wr_data | input | 8 | BCD write value |
| dst_en | input | 1 | Enables daylight-saving steps |
| dst_on_month | input | 8 | BCD month of spring-forward date |
| dst_on_date | input | 8 | BCD day of spring-forward date |
| dst_off_month | input | 8 | BCD month of fall-back date |
| dst_off_date | input | 8 | BCD day of fall-back date |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 00..23 |
| dow_o | output | 3 | Day of week, 0..6 |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| src_xtal_o | output | 1 | 1 while the crystal timebase is in use |
| sec_pulse_o | output | 1 | One-cycle pulse per second advance |

## Verification
The bench builds the block with XTAL_HZ set to 100 rather than the 32768 default. This brings a crystal second down to 100 ticks and the failover timeout down to 6 ticks. Both boundaries (one tick short and exactly reached) can then be visited within a short run.

LOCK_EDGES is 4, so the return to mains can be checked both one edge early and on the edge itself. The synchronizer depth stays at 2. Calendar corner cases are each reached by writing a time one second before the rollover of interest.

// File: rtl/mrtc_pkg.sv
// Shared types and BCD calendar helpers for the mains-synchronized clock.
// Assumes every calendar field holds valid packed BCD.
package mrtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] mins;
        logic [7:0] hour;
        logic [2:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    // Increment a two-digit BCD value (no wrap handling)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'h1};
        return r;
    endfunction

    // Leap when the two-digit BCD year is a multiple of four
    function automatic logic year_is_leap(input logic [7:0] y);
        logic even_tens;
        even_tens = ~y[4];
        return (even_tens  && (y[3:0] == 4'h0 || y[3:0] == 4'h4 || y[3:0] == 4'h8)) ||
               (!even_tens && (y[3:0] == 4'h2 || y[3:0] == 4'h6));
    endfunction

    // Last BCD date of a BCD month
    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
        logic [7:0] d;
        case (m)
            8'h02:                      d = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mrtc_timebase.sv
// Second-tick generator. Synchronizes the mains pulse, detects rising edges,
// supervises mains presence in crystal ticks and chooses the counting source.
// Assumes xtal_tick is a one-cycle enable in the clk domain and XTAL_HZ >= 60.
module mrtc_timebase #(
    parameter int XTAL_HZ     = 32768,
    parameter int LOCK_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_in,
    input  logic xtal_tick,
    input  logic sel_60,
    input  logic presc_clr,
    output logic on_xtal,
    output logic sec_tick
);
    localparam int PRE_MAX   = (XTAL_HZ > 60) ? XTAL_HZ : 60;
    localparam int PRE_W     = $clog2(PRE_MAX);
    localparam int GAP_LIMIT = (3 * XTAL_HZ + 49) / 50;
    localparam int GAP_W     = $clog2(GAP_LIMIT + 1);
    localparam int LOCK_W    = $clog2(LOCK_EDGES + 1);

    localparam logic [PRE_W-1:0]  XT_LAST  = PRE_W'(XTAL_HZ - 1);
    localparam logic [PRE_W-1:0]  M50_LAST = PRE_W'(49);
    localparam logic [PRE_W-1:0]  M60_LAST = PRE_W'(59);
    localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(GAP_LIMIT);
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_EDGES - 1);

    logic [SYNC_STAGES:0] sync_q;
    logic                 mains_edge;
    logic [GAP_W-1:0]     gap_cnt;
    logic                 gap_expired;
    logic [LOCK_W-1:0]    good_cnt;
    logic [LOCK_W-1:0]    good_nxt;
    logic                 on_xtal_nxt;
    logic                 src_switch;
    logic [PRE_W-1:0]     pre_cnt;
    logic [PRE_W-1:0]     pre_last;
    logic                 step;

    // Synchronizer chain; the extra top stage holds the previous synced level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], mains_in};
    end

    assign mains_edge  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign gap_expired = (gap_cnt == GAP_MAX);

    // Crystal ticks elapsed since the last mains edge, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                           gap_cnt <= '0;
        else if (mains_edge)                  gap_cnt <= '0;
        else if (xtal_tick && !gap_expired)   gap_cnt <= gap_cnt + 1'b1;
    end

    // Source selection: fail over on timeout, return after a run of edges
    always_comb begin
        on_xtal_nxt = on_xtal;
        good_nxt    = good_cnt;
        if (!on_xtal) begin
            good_nxt = '0;
            if (gap_expired) on_xtal_nxt = 1'b1;
        end else if (mains_edge) begin
            if (good_cnt == LOCK_LAST) begin
                on_xtal_nxt = 1'b0;
                good_nxt    = '0;
            end else begin
                good_nxt = good_cnt + 1'b1;
            end
        end else if (gap_expired) begin
            good_nxt = '0;
        end
    end

    assign src_switch = (on_xtal_nxt != on_xtal);

    // Source state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_xtal  <= 1'b0;
            good_cnt <= '0;
        end else begin
            on_xtal  <= on_xtal_nxt;
            good_cnt <= good_nxt;
        end
    end

    assign step     = on_xtal ? xtal_tick : mains_edge;
    assign pre_last = on_xtal ? XT_LAST : (sel_60 ? M60_LAST : M50_LAST);

    // Sub-second prescaler; cleared by writes and by a source change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= 1'b0;
            if (presc_clr || src_switch) begin
                pre_cnt <= '0;
            end else if (step) begin
                if (pre_cnt >= pre_last) begin
                    pre_cnt  <= '0;
                    sec_tick <= 1'b1;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mrtc_dst_match.sv
// Compares the current date with the two configured daylight-saving dates.
// Assumes all inputs are BCD; purely combinational.
module mrtc_dst_match (
    input  logic       dst_en,
    input  logic [7:0] cur_month,
    input  logic [7:0] cur_date,
    input  logic [7:0] on_month,
    input  logic [7:0] on_date,
    input  logic [7:0] off_month,
    input  logic [7:0] off_date,
    output logic       fwd_day,
    output logic       back_day
);
    // Day matches, gated by the enable
    always_comb begin
        fwd_day  = dst_en && (cur_month == on_month)  && (cur_date == on_date);
        back_day = dst_en && (cur_month == off_month) && (cur_date == off_date);
    end
endmodule

// File: rtl/mrtc_calendar.sv
// Time and calendar counters in BCD with a field write port.
// A write takes priority over a concurrent second tick. The fall-back
// flag keeps the repeated hour from being applied twice on the same day.
module mrtc_calendar
    import mrtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       fwd_day,
    input  logic       back_day,
    output rtc_time_t  now
);
    rtc_time_t nxt;
    logic      fell_back;
    logic      fell_back_nxt;
    logic      leap;

    assign leap = year_is_leap(now.year);

    // Next state for one second advance, including carries and DST steps
    always_comb begin
        nxt           = now;
        fell_back_nxt = fell_back;
        if (now.sec != 8'h59) begin
            nxt.sec = bcd_inc(now.sec);
        end else begin
            nxt.sec = 8'h00;
            if (now.mins != 8'h59) begin
                nxt.mins = bcd_inc(now.mins);
            end else begin
                nxt.mins = 8'h00;
                if (now.hour == 8'h01 && fwd_day) begin
                    nxt.hour = 8'h03;
                end else if (now.hour == 8'h01 && back_day && !fell_back) begin
                    nxt.hour      = 8'h01;
                    fell_back_nxt = 1'b1;
                end else if (now.hour != 8'h23) begin
                    nxt.hour = bcd_inc(now.hour);
                end else begin
                    nxt.hour      = 8'h00;
                    fell_back_nxt = 1'b0;
                    nxt.dow       = (now.dow == 3'd6) ? 3'd0 : now.dow + 3'd1;
                    if (now.date != month_last_day(now.month, leap)) begin
                        nxt.date = bcd_inc(now.date);
                    end else begin
                        nxt.date = 8'h01;
                        if (now.month != 8'h12) begin
                            nxt.month = bcd_inc(now.month);
                        end else begin
                            nxt.month = 8'h01;
                            nxt.year  = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
                        end
                    end
                end
            end
        end
    end

    // Field registers: reset, write, or second advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now.sec   <= 8'h00;
            now.mins  <= 8'h00;
            now.hour  <= 8'h00;
            now.dow   <= 3'd0;
            now.date  <= 8'h01;
            now.month <= 8'h01;
            now.year  <= 8'h00;
            fell_back <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                3'd0:    now.sec   <= wr_data;
                3'd1:    now.mins  <= wr_data;
                3'd2:    now.hour  <= wr_data;
                3'd3:    now.dow   <= wr_data[2:0];
                3'd4:    now.date  <= wr_data;
                3'd5:    now.month <= wr_data;
                3'd6:    now.year  <= wr_data;
                default: ;
            endcase
        end else if (sec_tick) begin
            now       <= nxt;
            fell_back <= fell_back_nxt;
        end
    end

endmodule

// File: rtl/mains_rtc.sv
// Top of the mains-synchronized clock calendar. Connects the timebase,
// the daylight-saving date match and the calendar counters.
// Assumes mains_in is a clean digital pulse and xtal_tick a clk-domain enable.
module mains_rtc
    import mrtc_pkg::*;
#(
    parameter int XTAL_HZ     = 32768,
    parameter int LOCK_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mains_in,
    input  logic       xtal_tick,
    input  logic       sel_60,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       dst_en,
    input  logic [7:0] dst_on_month,
    input  logic [7:0] dst_on_date,
    input  logic [7:0] dst_off_month,
    input  logic [7:0] dst_off_date,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       src_xtal_o,
    output logic       sec_pulse_o
);
    rtc_time_t now;
    logic      tick;
    logic      fwd_day;
    logic      back_day;

    mrtc_timebase #(
        .XTAL_HZ    (XTAL_HZ),
        .LOCK_EDGES (LOCK_EDGES),
        .SYNC_STAGES(SYNC_STAGES)
    ) tb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mains_in (mains_in),
        .xtal_tick(xtal_tick),
        .sel_60   (sel_60),
        .presc_clr(wr_en),
        .on_xtal  (src_xtal_o),
        .sec_tick (tick)
    );

    mrtc_dst_match dst_i (
        .dst_en   (dst_en),
        .cur_month(now.month),
        .cur_date (now.date),
        .on_month (dst_on_month),
        .on_date  (dst_on_date),
        .off_month(dst_off_month),
        .off_date (dst_off_date),
        .fwd_day  (fwd_day),
        .back_day (back_day)
    );

    mrtc_calendar cal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_tick(tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fwd_day (fwd_day),
        .back_day(back_day),
        .now     (now)
    );

    // Present the field registers and the tick at the ports
    always_comb begin
        sec_o       = now.sec;
        min_o       = now.mins;
        hour_o      = now.hour;
        dow_o       = now.dow;
        date_o      = now.date;
        month_o     = now.month;
        year_o      = now.year;
        sec_pulse_o = tick;
    end

endmodule

// File: rtl/mains_rtc_chk.sv
// Property checker for mains_rtc, attached through bind below.
module mains_rtc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       sec_pulse,
    input logic [7:0] sec,
    input logic [7:0] mins,
    input logic [7:0] hour,
    input logic [7:0] date,
    input logic [7:0] month
);
    // R4
    sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec <= 8'h59) && (sec[3:0] <= 4'h9) && (mins <= 8'h59) && (mins[3:0] <= 4'h9));

    // R4
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hour <= 8'h23) && (hour[3:0] <= 4'h9));

    // R5
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (month >= 8'h01) && (month <= 8'h12) && (date >= 8'h01) && (date <= 8'h31));

    // R12
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    // R3
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !wr_en) |=> ($stable(sec) && $stable(mins) && $stable(hour) &&
                                    $stable(date) && $stable(month)));

    // R2
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_en) |=> (sec != $past(sec)));
endmodule

bind mains_rtc mains_rtc_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sec_pulse(sec_pulse_o),
    .sec      (sec_o),
    .mins     (min_o),
    .hour     (hour_o),
    .date     (date_o),
    .month    (month_o)
);

// File: tb/mains_rtc_tb_top.sv
module mains_rtc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XTAL_HZ    = 100;
    localparam int LOCK_EDGES = 4;
    localparam int GAP_TICKS  = (3 * XTAL_HZ + 49) / 50;
    localparam int NV         = 13;

    // Each entry: {sec,min,hour,dow,date,month,year} start, then expected one second later
    localparam logic [111:0] VEC [0:NV-1] = '{
        {56'h00_00_00_00_01_01_00, 56'h01_00_00_00_01_01_00},  // R2 plain step
        {56'h09_10_12_03_15_06_23, 56'h10_10_12_03_15_06_23},  // R4 digit carry
        {56'h59_59_10_02_05_05_23, 56'h00_00_11_02_05_05_23},  // R4 hour carry
        {56'h59_59_23_06_31_01_23, 56'h00_00_00_00_01_02_23},  // R5 dow wrap, Jan 31
        {56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23},  // R6 non-leap Feb
        {56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24},  // R6 leap Feb 28
        {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24},  // R6 leap Feb 29
        {56'h59_59_23_04_30_04_24, 56'h00_00_00_05_01_05_24},  // R5 30-day month
        {56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_01_00},  // R6 year wrap
        {56'h59_59_23_00_28_02_00, 56'h00_00_00_01_29_02_00},  // R6 year 00 leap
        {56'h59_59_23_02_30_09_25, 56'h00_00_00_03_01_10_25},  // R5 Sep 30
        {56'h59_59_23_02_28_02_26, 56'h00_00_00_03_01_03_26},  // R6 year 26
        {56'h59_59_23_02_28_02_12, 56'h00_00_00_03_29_02_12}   // R6 year 12
    };

    logic       clk = 1'b0;
    logic       rst_n, mains_in, xtal_tick, sel_60, wr_en, dst_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, dst_on_month, dst_on_date, dst_off_month, dst_off_date;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] dow_o;
    logic       src_xtal_o, sec_pulse_o;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;

    mains_rtc #(.XTAL_HZ(XTAL_HZ), .LOCK_EDGES(LOCK_EDGES), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mains_in(mains_in), .xtal_tick(xtal_tick),
        .sel_60(sel_60), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dst_en(dst_en), .dst_on_month(dst_on_month), .dst_on_date(dst_on_date),
        .dst_off_month(dst_off_month), .dst_off_date(dst_off_date),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .src_xtal_o(src_xtal_o), .sec_pulse_o(sec_pulse_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (sec_pulse_o) pulse_cnt <= pulse_cnt + 1;

    function automatic logic [55:0] now_vec();
        return {sec_o, min_o, hour_o, 5'b0, dow_o, date_o, month_o, year_o};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [55:0] t);
        wr(3'd0, t[55:48]); wr(3'd1, t[47:40]); wr(3'd2, t[39:32]); wr(3'd3, t[31:24]);
        wr(3'd4, t[23:16]); wr(3'd5, t[15:8]);  wr(3'd6, t[7:0]);
    endtask

    task automatic mains_pulses(input int n);
        repeat (n) begin
            @(negedge clk); mains_in = 1'b1;
            @(negedge clk); mains_in = 1'b0;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic xtal_ticks(input int n);
        repeat (n) begin
            @(negedge clk); xtal_tick = 1'b1;
            @(negedge clk); xtal_tick = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; mains_in = 1'b0; xtal_tick = 1'b0; sel_60 = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; dst_en = 1'b0;
        dst_on_month = 8'h03; dst_on_date = 8'h10; dst_off_month = 8'h11; dst_off_date = 8'h03;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset fields", 64'(now_vec()), 64'(56'h00_00_00_00_01_01_00));
        chk("R1 reset source", 64'(src_xtal_o), 64'd0);

        // Table walk: R2..R6 on 50 Hz mains
        for (int i = 0; i < NV; i++) begin
            set_time(VEC[i][111:56]);
            mains_pulses(50);
            chk($sformatf("R4/R5/R6 vector %0d", i), 64'(now_vec()), 64'(VEC[i][55:0]));
        end

        // R2 60 Hz selection and R12 single pulse per second
        sel_60 = 1'b1;
        set_time(56'h00_00_08_01_02_03_04);
        pulse_cnt = 0;
        mains_pulses(59);
        chk("R2 59 edges at 60 Hz", 64'(sec_o), 64'h00);
        mains_pulses(1);
        chk("R2 60th edge at 60 Hz", 64'(sec_o), 64'h01);
        chk("R12 one pulse per second", 64'(pulse_cnt), 64'd1);

        // R3 write clears the sub-second count
        sel_60 = 1'b0;
        wr(3'd0, 8'h10);
        mains_pulses(30);
        wr(3'd0, 8'h20);
        mains_pulses(20);
        chk("R3 prescaler cleared by write", 64'(sec_o), 64'h20);
        mains_pulses(30);
        chk("R3 full count after write", 64'(sec_o), 64'h21);

        // R9 spring forward
        dst_en = 1'b1;
        set_time(56'h59_59_01_00_10_03_25);
        mains_pulses(50);
        chk("R9 forward step", 64'(now_vec()), 64'(56'h00_00_03_00_10_03_25));

        // R10 fall back, applied once
        set_time(56'h59_59_01_00_03_11_25);
        mains_pulses(50);
        chk("R10 fall back", 64'({hour_o, min_o, sec_o}), 64'h01_00_00);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        mains_pulses(50);
        chk("R10 second pass no repeat", 64'({hour_o, min_o, sec_o}), 64'h02_00_00);

        // R11 disabled on the start date
        dst_en = 1'b0;
        set_time(56'h59_59_01_00_10_03_25);
        mains_pulses(50);
        chk("R11 no step when disabled", 64'({hour_o, min_o, sec_o}), 64'h02_00_00);

        // R7 failover boundary
        xtal_ticks(GAP_TICKS - 1);
        chk("R7 no failover one tick early", 64'(src_xtal_o), 64'd0);
        xtal_ticks(1);
        chk("R7 failover at timeout", 64'(src_xtal_o), 64'd1);
        wr(3'd0, 8'h00);
        xtal_ticks(XTAL_HZ - 1);
        chk("R7 crystal second one tick early", 64'(sec_o), 64'h00);
        xtal_ticks(1);
        chk("R7 crystal second", 64'(sec_o), 64'h01);

        // R8 return to mains
        mains_pulses(LOCK_EDGES - 1);
        chk("R8 still on crystal", 64'(src_xtal_o), 64'd1);
        chk("R8 edges do not advance on crystal", 64'(sec_o), 64'h01);
        mains_pulses(1);
        chk("R8 back on mains", 64'(src_xtal_o), 64'd0);
        mains_pulses(50);
        chk("R8 mains second after return", 64'(sec_o), 64'h02);

        summary();
    end
endmodule